// File: doc/BRIEF.md
# Function Power-Down Request Filter

This block watches the activity of the sources that belong to one logical function: two serial channels and up to two general-purpose input pins. When every source reports idle at the same moment, a filter timer starts counting a slow tick input. If all sources stay idle for the whole programmed window, the block raises a power-down status bit for software to poll. It can also raise a power-down interrupt on the function's interrupt line. Any return of activity restarts the window and withdraws a pending request, so intermittent traffic cannot flood software with requests.

The block also holds the function's power state. Only a software write changes it, and the block never moves itself between states. In the low-power states D2 and D3 the block removes the serial-channel clock enable, masks the function interrupt output, and blocks I/O and memory BAR decoding. Configuration accesses are not decoded here and stay available. While the function is in a low-power state, any source activity can raise a wake (PME) output for this function alone.

Top module: `pd_request_filter`

## Requirements
- R1: A serial channel counts as idle only when its pending-interrupt input is 0 and both its transmit-idle and receive-idle inputs are 1.
- R2: A pin whose assign bit is 1 counts as idle when its level differs from its interrupt polarity bit (polarity 1 means a high level interrupts). A pin whose assign bit is 0 is ignored.
- R3: The filter timer advances on each cycle where `tick` is 1 and all sources are idle. In any cycle where some source is not idle, the timer returns to zero.
- R4: With filter code c, `pd_status` rises on the clock edge that consumes the 2^(c+4)-th qualifying tick of an unbroken idle run. The new value is visible after that edge.
- R5: `pd_status` is cleared by a one-cycle `pd_stat_clr` pulse or by any non-idle source. The clear wins over an expiry in the same cycle, and that cycle also restarts the timer.
- R6: `func_irq` equals (`pd_status` AND `pd_irq_en`) OR `norm_irq` while in D0, and is forced to 0 in D2 or D3 whatever the enables are.
- R7: `pstate` resets to D0 (00) and changes only on a `pstate_wr` cycle. A written 00 selects D0, 10 selects D2 and 11 selects D3. A written 01 is ignored.
- R8: In D2 or D3, `uart_clk_en` and `bar_en` are 0. In D0 both are 1.
- R9: `pme` is set when the function is in D2 or D3, `pme_en` is 1 and some source is not idle. It then holds until `pme_en` drops or the function has returned to D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timebase pulse for the filter |
| ch_irq_pend | input | NUM_CH | Per-channel pending interrupt |
| ch_tx_idle | input | NUM_CH | Per-channel transmitter idle |
| ch_rx_idle | input | NUM_CH | Per-channel receiver idle |
| pin_level | input | NUM_PIN | Current level of each general-purpose pin |
| pin_assign | input | NUM_PIN | Pin belongs to this function |
| pin_irq_pol | input | NUM_PIN | Level that makes the pin interrupt |
| filt_code | input | CODE_W | Filter window code |
| pd_irq_en | input | 1 | Enable for the power-down interrupt |
| norm_irq | input | 1 | Normal-operation interrupt of the function |
| pme_en | input | 1 | Wake event enable |
| pd_stat_clr | input | 1 | Write-one pulse clearing the status bit |
| pstate_wr | input | 1 | Power-state write strobe |
| pstate_wdata | input | 2 | Power-state write value |
| pd_status | output | 1 | Pollable power-down request |
| func_irq | output | 1 | Function interrupt line, active high |
| pstate | output | 2 | Current power state |
| uart_clk_en | output | 1 | Clock enable for the serial channels |
| bar_en | output | 1 | I/O and memory BAR decoding allowed |
| pme | output | 1 | Wake event for this function |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only away from its rising edge. They also assume that `pd_stat_clr` and `pstate_wr` are single-cycle strobes from a software write path. The bench drives every input on the falling edge and keeps both strobes to one cycle. It holds the filter code steady through each directed window, and its random phase leaves the sources idle most of the time so that windows really expire. The assertions make no assumption about tick spacing, and the bench varies it from every cycle to every third cycle.

// File: rtl/pd_filter_pkg.sv
package pd_filter_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  // number of qualifying ticks in the window chosen by a code
  function automatic int unsigned window_ticks(input int unsigned code,
                                               input int unsigned base_exp);
    return 32'd1 << (code + base_exp);
  endfunction

  // low-power states are the ones with the upper bit set
  function automatic logic is_low_power(input pwr_state_e st);
    return st[1];
  endfunction

  // codes that software may write; D1 is not supported
  function automatic logic state_legal(input logic [1:0] code);
    return code != PS_D1;
  endfunction

endpackage

// File: rtl/pd_src_idle.sv
module pd_src_idle #(
  parameter int NUM_CH  = 2,
  parameter int NUM_PIN = 2
) (
  input  logic [NUM_CH-1:0]  ch_irq_pend,
  input  logic [NUM_CH-1:0]  ch_tx_idle,
  input  logic [NUM_CH-1:0]  ch_rx_idle,
  input  logic [NUM_PIN-1:0] pin_level,
  input  logic [NUM_PIN-1:0] pin_assign,
  input  logic [NUM_PIN-1:0] pin_irq_pol,
  output logic               all_idle
);

  logic [NUM_CH-1:0]  ch_quiet;
  logic [NUM_PIN-1:0] pin_quiet;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_quiet[c] = ~ch_irq_pend[c] & ch_tx_idle[c] & ch_rx_idle[c];
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    // a pin not owned by this function never blocks the request
    assign pin_quiet[p] = ~pin_assign[p] | (pin_level[p] ^ pin_irq_pol[p]);
  end

  assign all_idle = (&ch_quiet) & (&pin_quiet);

endmodule

// File: rtl/pd_filter_timer.sv
module pd_filter_timer
  import pd_filter_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int BASE_EXP = 4,
  parameter int CNT_W    = BASE_EXP + (1 << CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              all_idle,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic              stat_clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire,
  output logic              pd_status
);

  logic [CNT_W:0] limit;
  logic [CNT_W:0] cnt_inc;
  logic           restart;

  assign limit   = (CNT_W+1)'(window_ticks(int'(code), BASE_EXP));
  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  assign restart = ~all_idle | stat_clr;
  assign expire  = ~restart & ~pd_status & tick & (cnt_inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || pd_status || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_status <= 1'b0;
    end else if (restart) begin
      pd_status <= 1'b0;
    end else if (expire) begin
      pd_status <= 1'b1;
    end
  end

endmodule

// File: rtl/pd_pstate_ctl.sv
module pd_pstate_ctl
  import pd_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       all_idle,
  input  logic       pme_en,
  output logic [1:0] pstate,
  output logic       low_power,
  output logic       uart_clk_en,
  output logic       bar_en,
  output logic       pme
);

  pwr_state_e state_q;
  logic       wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_D0;
    end else if (wr && state_legal(wdata)) begin
      state_q <= pwr_state_e'(wdata);
    end
  end

  assign pstate      = state_q;
  assign low_power   = is_low_power(state_q);
  assign uart_clk_en = ~low_power;
  assign bar_en      = ~low_power;
  assign wake_hit    = low_power & ~all_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme <= 1'b0;
    end else begin
      pme <= pme_en & low_power & (pme | wake_hit);
    end
  end

endmodule

// File: rtl/pd_request_filter.sv
module pd_request_filter
  import pd_filter_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int NUM_PIN  = 2,
  parameter int CODE_W   = 3,
  parameter int BASE_EXP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [NUM_CH-1:0]  ch_irq_pend,
  input  logic [NUM_CH-1:0]  ch_tx_idle,
  input  logic [NUM_CH-1:0]  ch_rx_idle,
  input  logic [NUM_PIN-1:0] pin_level,
  input  logic [NUM_PIN-1:0] pin_assign,
  input  logic [NUM_PIN-1:0] pin_irq_pol,
  input  logic [CODE_W-1:0]  filt_code,
  input  logic               pd_irq_en,
  input  logic               norm_irq,
  input  logic               pme_en,
  input  logic               pd_stat_clr,
  input  logic               pstate_wr,
  input  logic [1:0]         pstate_wdata,
  output logic               pd_status,
  output logic               func_irq,
  output logic [1:0]         pstate,
  output logic               uart_clk_en,
  output logic               bar_en,
  output logic               pme
);

  localparam int CNT_W = BASE_EXP + (1 << CODE_W);

  logic             all_idle;
  logic             tmr_expire;
  logic [CNT_W-1:0] tmr_cnt;
  logic             low_power;

  pd_src_idle #(
    .NUM_CH (NUM_CH),
    .NUM_PIN(NUM_PIN)
  ) u_idle (
    .ch_irq_pend(ch_irq_pend),
    .ch_tx_idle (ch_tx_idle),
    .ch_rx_idle (ch_rx_idle),
    .pin_level  (pin_level),
    .pin_assign (pin_assign),
    .pin_irq_pol(pin_irq_pol),
    .all_idle   (all_idle)
  );

  pd_filter_timer #(
    .CODE_W  (CODE_W),
    .BASE_EXP(BASE_EXP),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .all_idle (all_idle),
    .tick     (tick),
    .code     (filt_code),
    .stat_clr (pd_stat_clr),
    .cnt      (tmr_cnt),
    .expire   (tmr_expire),
    .pd_status(pd_status)
  );

  pd_pstate_ctl u_pstate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (pstate_wr),
    .wdata      (pstate_wdata),
    .all_idle   (all_idle),
    .pme_en     (pme_en),
    .pstate     (pstate),
    .low_power  (low_power),
    .uart_clk_en(uart_clk_en),
    .bar_en     (bar_en),
    .pme        (pme)
  );

  assign func_irq = ~low_power & ((pd_status & pd_irq_en) | norm_irq);

endmodule

// File: rtl/pd_filter_chk.sv
module pd_filter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             all_idle,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             pd_stat_clr,
  input logic             pstate_wr,
  input logic             pme_en,
  input logic             pd_status,
  input logic             func_irq,
  input logic [1:0]       pstate,
  input logic             uart_clk_en,
  input logic             bar_en,
  input logic             pme
);

  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !all_idle |=> tmr_cnt == '0);

  p_rise_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_status) |-> $past(all_idle && tick && !pd_stat_clr));

  p_clear_on_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_idle || pd_stat_clr) |=> !pd_status);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pstate[1] |-> !func_irq);

  p_state_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pstate_wr |=> $stable(pstate));

  p_no_d1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pstate != 2'b01);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pstate[1] |-> (!uart_clk_en && !bar_en));

  p_pme_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme) |-> $past(pstate[1] && pme_en && !all_idle));

endmodule

bind pd_request_filter pd_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .all_idle   (all_idle),
  .tmr_cnt    (tmr_cnt),
  .pd_stat_clr(pd_stat_clr),
  .pstate_wr  (pstate_wr),
  .pme_en     (pme_en),
  .pd_status  (pd_status),
  .func_irq   (func_irq),
  .pstate     (pstate),
  .uart_clk_en(uart_clk_en),
  .bar_en     (bar_en),
  .pme        (pme)
);

// File: tb/sim_pd_request_filter.sv
module sim_pd_request_filter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] ch_irq_pend = 2'b00;
  logic [1:0] ch_tx_idle = 2'b11;
  logic [1:0] ch_rx_idle = 2'b11;
  logic [1:0] pin_level = 2'b00;
  logic [1:0] pin_assign = 2'b00;
  logic [1:0] pin_irq_pol = 2'b00;
  logic [2:0] filt_code = 3'd0;
  logic       pd_irq_en = 1'b0;
  logic       norm_irq = 1'b0;
  logic       pme_en = 1'b0;
  logic       pd_stat_clr = 1'b0;
  logic       pstate_wr = 1'b0;
  logic [1:0] pstate_wdata = 2'b00;
  logic       pd_status, func_irq, uart_clk_en, bar_en, pme;
  logic [1:0] pstate;

  pd_request_filter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ch_irq_pend(ch_irq_pend), .ch_tx_idle(ch_tx_idle), .ch_rx_idle(ch_rx_idle),
    .pin_level(pin_level), .pin_assign(pin_assign), .pin_irq_pol(pin_irq_pol),
    .filt_code(filt_code), .pd_irq_en(pd_irq_en), .norm_irq(norm_irq),
    .pme_en(pme_en), .pd_stat_clr(pd_stat_clr), .pstate_wr(pstate_wr),
    .pstate_wdata(pstate_wdata), .pd_status(pd_status), .func_irq(func_irq),
    .pstate(pstate), .uart_clk_en(uart_clk_en), .bar_en(bar_en), .pme(pme)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  string cur_req = "R7";

  // reference model state
  int m_cnt = 0;
  bit m_stat = 0;
  int m_ps = 0;
  bit m_pme = 0;

  function automatic bit ref_idle();
    for (int c = 0; c < 2; c++)
      if (ch_irq_pend[c] || !ch_tx_idle[c] || !ch_rx_idle[c]) return 0;
    for (int p = 0; p < 2; p++)
      if (pin_assign[p] && (pin_level[p] == pin_irq_pol[p])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_stat = 0; m_ps = 0; m_pme = 0;
    end else begin
      bit idle;
      bit lp;
      int win;
      idle = ref_idle();
      lp   = (m_ps >= 2);
      win  = 2 ** (filt_code + 4);
      m_pme = pme_en && lp && (m_pme || !idle);
      if (!idle || pd_stat_clr) begin
        m_stat = 0; m_cnt = 0;
      end else if (m_stat) begin
        m_cnt = 0;
      end else if (tick) begin
        if (m_cnt + 1 >= win) begin m_stat = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      if (pstate_wr && pstate_wdata != 2'b01) m_ps = pstate_wdata;
    end
  end

  task automatic chk(input string what, input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit lp;
    lp = (m_ps >= 2);
    chk("pd_status", pd_status, m_stat, cur_req);
    chk("func_irq", func_irq, (!lp && ((m_stat && pd_irq_en) || norm_irq)) ? 1 : 0, "R6");
    chk("pstate", pstate, m_ps, "R7");
    chk("uart_clk_en", uart_clk_en, lp ? 0 : 1, "R8");
    chk("bar_en", bar_en, lp ? 0 : 1, "R8");
    chk("pme", pme, m_pme, "R9");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse_clr();
    pd_stat_clr = 1'b1; step(1); pd_stat_clr = 1'b0;
  endtask

  task automatic write_ps(input logic [1:0] v);
    pstate_wr = 1'b1; pstate_wdata = v; step(1); pstate_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset values
    cur_req = "R7"; step(1);
    chk("reset status", pd_status, 0, "R4");
    chk("reset state", pstate, 0, "R7");

    // R1: channel idleness, tick every cycle, code 0 = 16 ticks
    cur_req = "R1"; tick = 1'b1;
    step(20);
    chk("status after idle window", pd_status, 1, "R1");
    ch_tx_idle = 2'b01; step(1);
    chk("tx busy clears", pd_status, 0, "R1");
    ch_tx_idle = 2'b11; ch_rx_idle = 2'b10; step(30);
    chk("rx busy blocks", pd_status, 0, "R1");
    ch_rx_idle = 2'b11; ch_irq_pend = 2'b10; step(30);
    chk("pending irq blocks", pd_status, 0, "R1");
    ch_irq_pend = 2'b00;

    // R2: pin polarity and assignment
    cur_req = "R2";
    pin_assign = 2'b01; pin_irq_pol = 2'b01; pin_level = 2'b01; step(30);
    chk("pin at irq level blocks", pd_status, 0, "R2");
    pin_level = 2'b10; step(17);
    chk("pin opposite level idle", pd_status, 1, "R2");
    pin_level = 2'b00; step(5);
    chk("unassigned pin ignored", pd_status, 1, "R2");
    pin_assign = 2'b11; pin_irq_pol = 2'b01; step(1);
    chk("assigned low-pol pin low blocks", pd_status, 0, "R2");
    pin_assign = 2'b00;

    // R3: interruption mid window restarts the count
    cur_req = "R3";
    step(10);
    ch_irq_pend = 2'b01; step(1); ch_irq_pend = 2'b00;
    step(15);
    chk("restart not expired at 15", pd_status, 0, "R3");
    step(2);
    chk("restart expired at 16", pd_status, 1, "R3");
    pulse_clr();

    // R4: longer window, sparse ticks
    cur_req = "R4"; filt_code = 3'd3;
    for (int i = 0; i < 127 * 3; i++) begin
      tick = (i % 3 == 0); step(1);
    end
    chk("no expiry before 128 ticks", pd_status, 0, "R4");
    tick = 1'b1; step(1); tick = 1'b0; step(1);
    chk("expiry at 128 ticks", pd_status, 1, "R4");
    filt_code = 3'd7; pulse_clr(); tick = 1'b1;
    step(2048);
    chk("longest window", pd_status, 1, "R4");
    filt_code = 3'd0;

    // R5: clear wins over expiry
    cur_req = "R5"; pulse_clr();
    step(15);
    pulse_clr(); step(1);
    chk("clear beats expiry", pd_status, 0, "R5");
    step(16);
    chk("re-armed after clear", pd_status, 1, "R5");

    // R6: interrupt gating
    cur_req = "R6"; pd_irq_en = 1'b1; step(2);
    chk("pd interrupt", func_irq, 1, "R6");
    pd_irq_en = 1'b0; norm_irq = 1'b1; step(2);
    chk("normal interrupt passes", func_irq, 1, "R6");

    // R7/R8: power state writes
    cur_req = "R7"; pd_irq_en = 1'b1;
    write_ps(2'b10); step(1);
    chk("D2 entered", pstate, 2, "R7");
    chk("irq masked in D2", func_irq, 0, "R6");
    chk("clock gated", uart_clk_en, 0, "R8");
    write_ps(2'b01); step(1);
    chk("D1 write ignored", pstate, 2, "R7");
    write_ps(2'b11); step(1);
    chk("D3 entered", pstate, 3, "R7");
    chk("bar blocked", bar_en, 0, "R8");
    step(40);
    chk("state held", pstate, 3, "R7");

    // R9: wake event
    cur_req = "R9"; ch_irq_pend = 2'b01; step(2);
    chk("no pme when disabled", pme, 0, "R9");
    pme_en = 1'b1; step(1);
    chk("pme raised", pme, 1, "R9");
    ch_irq_pend = 2'b00; step(3);
    chk("pme held", pme, 1, "R9");
    write_ps(2'b00); step(1);
    chk("pme cleared in D0", pme, 0, "R9");
    chk("clock back in D0", uart_clk_en, 1, "R8");

    // mixed random traffic
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      ch_irq_pend = ($urandom % 60 == 0) ? 2'b01 : 2'b00;
      ch_tx_idle  = ($urandom % 80 == 0) ? 2'b10 : 2'b11;
      pin_assign  = 2'($urandom);
      pin_irq_pol = 2'b11;
      pin_level   = ($urandom % 50 == 0) ? 2'b11 : 2'b00;
      tick        = ($urandom % 2 == 0);
      norm_irq    = ($urandom % 7 == 0);
      pd_irq_en   = ($urandom % 2 == 0);
      pme_en      = ($urandom % 4 != 0);
      pd_stat_clr = ($urandom % 97 == 0);
      pstate_wr   = ($urandom % 150 == 0);
      pstate_wdata = 2'($urandom);
      step(1);
    end
    pd_stat_clr = 1'b0; pstate_wr = 1'b0;
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule